// File: doc/BRIEF.md
# EDO DRAM Access Controller

This block sits between a host that issues single-byte read and write requests and an x8 extended-data-out DRAM. It turns each request into the strobe sequence the memory expects: the row half of the address is placed on the multiplexed address bus when the row strobe (`dram_ras_n`) falls, and the column half follows when the column strobe (`dram_cas_n`) falls. After an access the row is left open. A following request to the same row only cycles the column strobe, which is page mode. A request to another row first closes the page and waits out the row precharge time.

Read data is not taken while the column strobe is low. Extended-data-out parts keep the output valid after the column strobe rises, as long as the row strobe and output enable stay low. The controller therefore samples the data bus on the last clock of the column precharge window. Writes are early writes: the write strobe goes low before the column strobe falls, so the part captures the data on that fall. Every timing minimum is given in nanoseconds and turned into a clock count that is rounded up. A refresh arbiter can take the memory with `ref_gnt`. While the grant is held the controller accepts nothing, finishes the access in flight and then parks the row strobe high.

The request port follows valid/ready rules. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The host must hold the address, direction and data steady until then. `req_ready` is high only when the controller is idle or has a row open, and never while `ref_gnt` is high. Read results cannot be held back: `rd_valid` is a one-cycle pulse, and results come back in the order the reads were accepted.

Top module: `edo_ctrl`

## Requirements
- R1: After reset, all four strobes (`dram_ras_n`, `dram_cas_n`, `dram_we_n`, `dram_oe_n`) are high, `busy` is low, `dram_dq_oe` is low, `rd_valid` is low and `req_ready` is high.
- R2: With the default geometry (`ROW_HEAVY`=1), `req_addr[22:10]` is the 13-bit row and `req_addr[9:0]` is the 10-bit column. With `ROW_HEAVY`=0, the row is `req_addr[22:11]` (12 bits) and the column is `req_addr[10:0]` (11 bits). The row is on `dram_addr` when `dram_ras_n` falls, and the column, zero-extended, is on `dram_addr` when `dram_cas_n` falls.
- R3: For a write (`req_we`=1), `dram_we_n` is already low one clock before `dram_cas_n` falls. `dram_dq_oe` is high and `dram_dq_out` carries the request's byte at that fall. `dram_oe_n` stays high whenever `dram_we_n` is low.
- R4: For a read, `dram_we_n` is high when `dram_cas_n` falls, and `dram_oe_n` is low from that fall through the column precharge window. `rd_data` is the byte on `dram_dq_in` at the last clock of that window. `rd_valid` pulses once per read, in acceptance order.
- R5: A request whose row equals the open row is served with no rise of `dram_ras_n`. Only `dram_cas_n` cycles.
- R6: Before every fall of `dram_ras_n`, the row strobe has been high for at least the row precharge count. Two successive falls of the row strobe are at least the random cycle count apart.
- R7: `dram_cas_n` falls at least the row-to-column count of cycles after `dram_ras_n` falls. It stays low for at least the column pulse count. Between page accesses it stays high for at least the larger of the precharge count and (page cycle count minus pulse count).
- R8: `dram_cas_n` is never low for more than the maximum column pulse count (10,000 ns by default).
- R9: While `ref_gnt` is high, `req_ready` is low, no new access starts, and once the access in flight ends `dram_ras_n` goes high and stays high. After the grant drops, the next access begins with a fresh row activation.
- R10: `busy` is high whenever the controller is not idle, including whenever `dram_ras_n` is low. It is low once the row is closed and nothing is pending.
- R11: `dram_addr` does not change while `dram_cas_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller takes the request on this edge if valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (23) | Byte address, row in the upper bits |
| req_wdata | input | DQ_W (8) | Write byte |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |
| rd_data | output | DQ_W (8) | Read byte |
| busy | output | 1 | Controller not idle |
| ref_gnt | input | 1 | Memory granted to the refresh side |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | BUS_W (13) | Multiplexed row/column address |
| dram_dq_out | output | DQ_W (8) | Data toward the memory |
| dram_dq_oe | output | 1 | Enable for the pad driver of `dram_dq_out` |
| dram_dq_in | input | DQ_W (8) | Data from the memory |

## Verification
Two functions can fall in the same cycle: a refresh grant and a pending same-row request while the page is open. The bench opens a row, raises `ref_gnt`, and then presents a read to that same row while the grant is still held. The check passes if the request is never accepted and the row strobe stays high with no activation for the whole grant. When the grant drops, exactly one new row activation must follow, and the read must return the byte written earlier. Random traffic over a few rows adds the same collision at random points, together with the strobe-timing checks.

// File: rtl/edo_pkg.sv
package edo_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACT,
    ST_WSET,
    ST_CASL,
    ST_CASH,
    ST_OPEN,
    ST_PRE
  } edo_st_e;

  // nanoseconds to clock cycles, rounded up, never below one
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/edo_addr_map.sv
module edo_addr_map #(
  parameter int ADDR_W = 23,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int BUS_W  = 13
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [BUS_W-1:0]  row_bus,
  output logic [BUS_W-1:0]  col_bus
);

  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col;

  assign row = addr[ADDR_W-1:COL_W];
  assign col = addr[COL_W-1:0];

  generate
    if (ROW_W == BUS_W) begin : g_row_full
      assign row_bus = row;
    end else begin : g_row_pad
      assign row_bus = {{(BUS_W-ROW_W){1'b0}}, row};
    end
    if (COL_W == BUS_W) begin : g_col_full
      assign col_bus = col;
    end else begin : g_col_pad
      assign col_bus = {{(BUS_W-COL_W){1'b0}}, col};
    end
  endgenerate

endmodule

// File: rtl/edo_timer.sv
module edo_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/edo_seq.sv
module edo_seq
  import edo_pkg::*;
#(
  parameter int BUS_W   = 13,
  parameter int DQ_W    = 8,
  parameter int RCD_C   = 4,
  parameter int CAS_C   = 2,
  parameter int CPW_C   = 1,
  parameter int RP_C    = 3,
  parameter int RC_C    = 9,
  parameter int CMAX_C  = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_we,
  input  logic [BUS_W-1:0] req_row,
  input  logic [BUS_W-1:0] req_col,
  input  logic [DQ_W-1:0]  req_wdata,
  input  logic             ref_gnt,
  output logic             busy,
  output logic             rd_valid,
  output logic [DQ_W-1:0]  rd_data,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic             oe_n,
  output logic [BUS_W-1:0] addr_out,
  output logic [DQ_W-1:0]  dq_out,
  output logic             dq_oe,
  input  logic [DQ_W-1:0]  dq_in
);

  localparam int TMAX  = imax(imax(RCD_C, CAS_C), imax(imax(CPW_C, RP_C), RC_C));
  localparam int CNT_W = $clog2(TMAX + 1);
  localparam int MON_W = 16;
  localparam logic [MON_W-1:0] MON_SAT = '1;

  edo_st_e            st, nxt;
  logic               accept, hit, pend, pend_nxt;
  logic               t_ld, t_done, rc_ld, rc_done;
  logic [CNT_W-1:0]   t_val;
  logic               cur_we;
  logic [BUS_W-1:0]   cur_row, cur_col;
  logic [DQ_W-1:0]    cur_wdata;

  assign req_ready = ((st == ST_IDLE) || (st == ST_OPEN)) && !ref_gnt;
  assign accept    = req_valid && req_ready;
  assign hit       = (req_row == cur_row);

  // next state
  always_comb begin
    nxt      = st;
    pend_nxt = pend;
    unique case (st)
      ST_IDLE: if (accept) nxt = ST_ACT;
      ST_ACT:  if (t_done) nxt = ST_CASL;
      ST_WSET: nxt = ST_CASL;
      ST_CASL: if (t_done) nxt = ST_CASH;
      ST_CASH: if (t_done) nxt = ref_gnt ? ST_PRE : ST_OPEN;
      ST_OPEN: begin
        if (ref_gnt) begin
          nxt = ST_PRE;
        end else if (accept) begin
          if (hit) begin
            nxt = req_we ? ST_WSET : ST_CASL;
          end else begin
            nxt      = ST_PRE;
            pend_nxt = 1'b1;
          end
        end
      end
      ST_PRE: begin
        if (t_done && rc_done) begin
          if (!pend)         nxt = ST_IDLE;
          else if (!ref_gnt) nxt = ST_ACT;
        end
      end
      default: nxt = ST_IDLE;
    endcase
    if (nxt == ST_ACT) pend_nxt = 1'b0;
  end

  // per-state hold counts
  always_comb begin
    unique case (nxt)
      ST_ACT:  t_val = CNT_W'(RCD_C - 1);
      ST_CASL: t_val = CNT_W'(CAS_C - 1);
      ST_CASH: t_val = CNT_W'(CPW_C - 1);
      ST_PRE:  t_val = CNT_W'(RP_C - 1);
      default: t_val = '0;
    endcase
  end

  assign t_ld  = (nxt != st);
  assign rc_ld = (nxt == ST_ACT) && (st != ST_ACT);

  edo_timer #(.W(CNT_W)) i_state_tmr (
    .clk(clk), .rst_n(rst_n), .load(t_ld), .load_val(t_val), .done(t_done)
  );

  edo_timer #(.W(CNT_W)) i_cycle_tmr (
    .clk(clk), .rst_n(rst_n), .load(rc_ld), .load_val(CNT_W'(RC_C - 1)), .done(rc_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      pend      <= 1'b0;
      cur_we    <= 1'b0;
      cur_row   <= '0;
      cur_col   <= '0;
      cur_wdata <= '0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      st   <= nxt;
      pend <= pend_nxt;
      if (accept) begin
        cur_we    <= req_we;
        cur_row   <= req_row;
        cur_col   <= req_col;
        cur_wdata <= req_wdata;
      end
      // late sample inside the column precharge window
      if ((st == ST_CASH) && t_done && !cur_we) begin
        rd_valid <= 1'b1;
        rd_data  <= dq_in;
      end else begin
        rd_valid <= 1'b0;
      end
    end
  end

  // strobe decode
  assign busy     = (st != ST_IDLE);
  assign ras_n    = !(st inside {ST_ACT, ST_WSET, ST_CASL, ST_CASH, ST_OPEN});
  assign cas_n    = (st != ST_CASL);
  assign we_n     = !(cur_we && (st inside {ST_ACT, ST_WSET, ST_CASL}));
  assign dq_oe    = cur_we && (st inside {ST_ACT, ST_WSET, ST_CASL});
  assign oe_n     = !(!cur_we && (st inside {ST_CASL, ST_CASH}));
  assign addr_out = (st == ST_ACT) ? cur_row : cur_col;
  assign dq_out   = cur_wdata;

  // run-length monitors used by the assertions
  logic [MON_W-1:0] m_ras_hi, m_ras_lo, m_cas_hi, m_cas_lo, m_since_act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_ras_hi    <= MON_SAT;
      m_ras_lo    <= '0;
      m_cas_hi    <= MON_SAT;
      m_cas_lo    <= '0;
      m_since_act <= MON_SAT;
    end else begin
      m_ras_hi    <= ras_n  ? ((m_ras_hi == MON_SAT) ? m_ras_hi : m_ras_hi + 1'b1) : '0;
      m_ras_lo    <= !ras_n ? ((m_ras_lo == MON_SAT) ? m_ras_lo : m_ras_lo + 1'b1) : '0;
      m_cas_hi    <= cas_n  ? ((m_cas_hi == MON_SAT) ? m_cas_hi : m_cas_hi + 1'b1) : '0;
      m_cas_lo    <= !cas_n ? ((m_cas_lo == MON_SAT) ? m_cas_lo : m_cas_lo + 1'b1) : '0;
      m_since_act <= (!ras_n && (m_ras_lo == '0)) ? MON_W'(1)
                   : ((m_since_act == MON_SAT) ? m_since_act : m_since_act + 1'b1);
    end
  end

  // R6
  rp_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (m_ras_hi >= MON_W'(RP_C)));

  // R6
  rc_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (m_since_act >= MON_W'(RC_C)));

  // R7
  rcd_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> (m_ras_lo >= MON_W'(RCD_C)) && (m_cas_hi >= MON_W'(CPW_C)));

  // R7
  cas_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_n) |-> (m_cas_lo >= MON_W'(CAS_C)));

  // R8
  cas_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_cas_lo <= MON_W'(CMAX_C)));

  // R3
  early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && !we_n) |-> ($past(!we_n) && dq_oe && oe_n));

  // R4
  read_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(!oe_n));

  // R9
  ref_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_gnt && $past(ref_gnt) && $past(ras_n)) |-> ras_n);

  // R11
  col_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n && $past(!cas_n)) |-> $stable(addr_out));

  // R10
  busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> busy);

endmodule

// File: rtl/edo_ctrl.sv
module edo_ctrl
  import edo_pkg::*;
#(
  parameter int ADDR_W      = 23,
  parameter bit ROW_HEAVY   = 1'b1,
  parameter int DQ_W        = 8,
  parameter int CLK_NS      = 10,
  parameter int RAC_NS      = 50,
  parameter int CAC_NS      = 13,
  parameter int CAS_MIN_NS  = 8,
  parameter int CP_NS       = 8,
  parameter int PC_NS       = 20,
  parameter int RC_NS       = 84,
  parameter int RP_NS       = 30,
  parameter int CAS_MAX_NS  = 10000,
  localparam int ROW_W      = ROW_HEAVY ? (ADDR_W + 3) / 2 : (ADDR_W + 1) / 2,
  localparam int COL_W      = ADDR_W - ROW_W,
  localparam int BUS_W      = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DQ_W-1:0]   req_wdata,
  output logic              rd_valid,
  output logic [DQ_W-1:0]   rd_data,
  output logic              busy,
  input  logic              ref_gnt,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic              dram_oe_n,
  output logic [BUS_W-1:0]  dram_addr,
  output logic [DQ_W-1:0]   dram_dq_out,
  output logic              dram_dq_oe,
  input  logic [DQ_W-1:0]   dram_dq_in
);

  localparam int RCD_C  = ns_to_cyc(RAC_NS - CAC_NS, CLK_NS);
  localparam int CAS_C  = imax(ns_to_cyc(CAC_NS, CLK_NS), ns_to_cyc(CAS_MIN_NS, CLK_NS));
  localparam int CPW_C  = imax(ns_to_cyc(CP_NS, CLK_NS), ns_to_cyc(PC_NS, CLK_NS) - CAS_C);
  localparam int RP_C   = ns_to_cyc(RP_NS, CLK_NS);
  localparam int RC_C   = ns_to_cyc(RC_NS, CLK_NS);
  localparam int CMAX_C = CAS_MAX_NS / CLK_NS;

  logic [BUS_W-1:0] row_bus, col_bus;

  edo_addr_map #(
    .ADDR_W(ADDR_W), .ROW_W(ROW_W), .COL_W(COL_W), .BUS_W(BUS_W)
  ) i_map (
    .addr(req_addr), .row_bus(row_bus), .col_bus(col_bus)
  );

  edo_seq #(
    .BUS_W(BUS_W), .DQ_W(DQ_W), .RCD_C(RCD_C), .CAS_C(CAS_C),
    .CPW_C(CPW_C), .RP_C(RP_C), .RC_C(RC_C), .CMAX_C(CMAX_C)
  ) i_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_row(row_bus), .req_col(col_bus), .req_wdata(req_wdata),
    .ref_gnt(ref_gnt), .busy(busy),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .ras_n(dram_ras_n), .cas_n(dram_cas_n), .we_n(dram_we_n), .oe_n(dram_oe_n),
    .addr_out(dram_addr), .dq_out(dram_dq_out), .dq_oe(dram_dq_oe),
    .dq_in(dram_dq_in)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> (dram_ras_n && dram_cas_n && !busy));

endmodule

// File: tb/test_edo_ctrl.sv
module test_edo_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int ROW_W = 13;
  localparam int COL_W = 10;
  localparam int BUS_W = 13;

  function automatic int up(input int ns);
    return (ns + CLK_PERIOD - 1) / CLK_PERIOD;
  endfunction
  localparam int E_RCD  = up(50 - 13);
  localparam int E_CAS  = (up(13) > up(8)) ? up(13) : up(8);
  localparam int E_CPW  = (up(8) > up(20) - E_CAS) ? up(8) : up(20) - E_CAS;
  localparam int E_RP   = up(30);
  localparam int E_RC   = up(84);
  localparam int E_CMAX = 10000 / CLK_PERIOD;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_we = 0, ref_gnt = 0;
  logic [22:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rd_valid, busy;
  logic [7:0] rd_data;
  logic ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [BUS_W-1:0] addr;
  logic [7:0] dq_out, dq_in, dout;

  always #(CLK_PERIOD/2) clk = ~clk;

  edo_ctrl i_edo_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy), .ref_gnt(ref_gnt),
    .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_oe_n(oe_n),
    .dram_addr(addr), .dram_dq_out(dq_out), .dram_dq_oe(dq_oe), .dram_dq_in(dq_in)
  );

  int n_chk = 0, n_bad = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // memory model and host-side shadow
  logic [7:0] dmem[int];
  logic [7:0] smem[int];
  bit         q_we[$];
  int         q_row[$], q_col[$], q_dat[$], exp_rd[$];
  bit in_req = 0;

  function automatic logic [7:0] peek(input int key);
    if (smem.exists(key)) return smem[key];
    return 8'h00;
  endfunction

  assign dq_in = oe_n ? 8'hA5 : dout;

  // monitor
  bit p_ras = 1, p_cas = 1, p_we = 1, p_ref = 0;
  logic [BUS_W-1:0] p_addr = '0;
  int ras_lo = 0, ras_hi = 1000, cas_lo = 0, cas_hi = 1000, since_act = 1000;
  int row_l = 0, ras_falls = 0, ras_rises = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!ras_n && p_ras) begin
        chk(ras_hi >= E_RP, "R6 precharge", ras_hi, E_RP);
        chk(since_act >= E_RC, "R6 cycle", since_act, E_RC);
        chk(!(ref_gnt && p_ref), "R9 no activation under grant", 1, 0);
        row_l = int'(addr);
        ras_falls++;
        since_act = 0;
      end
      if (ras_n && !p_ras) ras_rises++;
      if (!cas_n && p_cas) begin
        chk(ras_lo >= E_RCD, "R7 row-to-column", ras_lo, E_RCD);
        chk(cas_hi >= E_CPW, "R7 column precharge", cas_hi, E_CPW);
        chk(!(ref_gnt && p_ref && p_ras), "R9 no access under grant", 1, 0);
        if (q_we.size() == 0) begin
          chk(0, "R10 unrequested access", 1, 0);
        end else begin
          bit w; int r, c, d;
          w = q_we.pop_front(); r = q_row.pop_front();
          c = q_col.pop_front(); d = q_dat.pop_front();
          chk(row_l == r, "R2 row", row_l, r);
          chk(int'(addr) == c, "R2 column", int'(addr), c);
          if (w) begin
            chk(!p_we && !we_n, "R3 early write", {p_we, we_n}, 0);
            chk(dq_oe && oe_n, "R3 drive and oe", {dq_oe, oe_n}, 3);
            chk(int'(dq_out) == d, "R3 write data", dq_out, d);
            dmem[(r << COL_W) | c] = dq_out;
          end else begin
            chk(we_n, "R4 read strobe", we_n, 1);
            dout = dmem.exists((r << COL_W) | c) ? dmem[(r << COL_W) | c] : 8'h00;
          end
        end
      end
      if (!cas_n && !p_cas) chk(addr == p_addr, "R11 column hold", addr, p_addr);
      if (cas_n && !p_cas) begin
        chk(cas_lo >= E_CAS, "R7 column pulse", cas_lo, E_CAS);
        chk(cas_lo <= E_CMAX, "R8 column max", cas_lo, E_CMAX);
      end
      if (!we_n && !oe_n) chk(0, "R3 oe during write", oe_n, 1);
      if (!ras_n && !busy) chk(0, "R10 busy while row low", busy, 1);
      if (ref_gnt && req_ready) chk(0, "R9 ready under grant", req_ready, 0);
      if (rd_valid) begin
        if (exp_rd.size() == 0) chk(0, "R4 extra read strobe", 1, 0);
        else begin
          int e; e = exp_rd.pop_front();
          chk(int'(rd_data) == e, "R4 read data", rd_data, e);
        end
      end
    end
    ras_lo = ras_n ? 0 : ras_lo + 1;
    ras_hi = ras_n ? ras_hi + 1 : 0;
    cas_lo = cas_n ? 0 : cas_lo + 1;
    cas_hi = cas_n ? cas_hi + 1 : 0;
    since_act++;
    p_ras = ras_n; p_cas = cas_n; p_we = we_n; p_ref = ref_gnt; p_addr = addr;
  end

  task automatic do_req(input bit w, input int r, input int c, input logic [7:0] d);
    int key;
    in_req = 1;
    @(negedge clk);
    req_valid = 1; req_we = w; req_addr = 23'((r << COL_W) | c); req_wdata = d;
    while (!req_ready) @(negedge clk);
    key = (r << COL_W) | c;
    q_we.push_back(w); q_row.push_back(r); q_col.push_back(c); q_dat.push_back(int'(d));
    if (w) smem[key] = d;
    else exp_rd.push_back(int'(peek(key)));
    @(posedge clk); #1;
    req_valid = 0;
    in_req = 0;
  endtask

  task automatic drain();
    repeat (2) @(negedge clk);
    while (in_req || q_we.size() != 0 || exp_rd.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  bit finished = 0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(0, "watchdog", 0, 1);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int f0, r0;
    dout = 8'h00;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(ras_n && cas_n && we_n && oe_n, "R1 strobes high", {ras_n, cas_n, we_n, oe_n}, 15);
    chk(!busy && !dq_oe && !rd_valid, "R1 quiet outputs", {busy, dq_oe, rd_valid}, 0);
    chk(req_ready, "R1 ready", req_ready, 1);

    // R5 page hit: write then read the same row
    f0 = ras_falls; r0 = ras_rises;
    do_req(1, 5, 3, 8'h3C);
    do_req(0, 5, 7, 8'h00);
    do_req(0, 5, 3, 8'h00);
    drain();
    chk(ras_falls - f0 == 1, "R5 single activation", ras_falls - f0, 1);
    chk(ras_rises == r0, "R5 row held open", ras_rises - r0, 0);
    chk(busy, "R10 busy with row open", busy, 1);

    // R6 row miss closes and reopens
    do_req(1, 6, 1023, 8'hE1);
    drain();
    chk(ras_falls - f0 == 2, "R6 miss activation", ras_falls - f0, 2);
    chk(ras_rises - r0 == 1, "R6 miss close", ras_rises - r0, 1);

    // R9 grant while row open, then same-row read under grant
    @(posedge clk); #2 ref_gnt = 1;
    repeat (2) @(negedge clk);
    chk(!req_ready, "R9 ready low", req_ready, 0);
    repeat (E_RP + E_RC) @(negedge clk);
    chk(ras_n, "R9 row parked", ras_n, 1);
    chk(!busy, "R10 idle after close", busy, 0);
    f0 = ras_falls;
    fork do_req(0, 6, 1023, 8'h00); join_none
    repeat (8) @(negedge clk);
    chk(ras_falls == f0, "R9 no activation while granted", ras_falls - f0, 0);
    chk(exp_rd.size() == 0, "R9 request held off", exp_rd.size(), 0);
    @(posedge clk); #2 ref_gnt = 0;
    drain();
    chk(ras_falls - f0 == 1, "R9 fresh activation", ras_falls - f0, 1);

    // random traffic over few rows with occasional grants
    for (int i = 0; i < 120; i++) begin
      int r, c, g;
      r = 20 + int'($urandom_range(0, 3));
      c = int'($urandom_range(0, 1023));
      if ($urandom_range(0, 9) == 0) begin
        g = int'($urandom_range(1, 12));
        @(posedge clk); #2 ref_gnt = 1;
        fork
          begin repeat (g) @(posedge clk); #2 ref_gnt = 0; end
        join_none
      end
      do_req($urandom_range(0, 1) == 1, r, c, 8'($urandom));
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end
    // directed read-back of corner columns (R2)
    do_req(1, 8191, 0, 8'h81);
    do_req(0, 8191, 0, 8'h00);
    do_req(0, 20, 1023, 8'h00);
    drain();
    chk(q_we.size() == 0, "R10 all requests served", q_we.size(), 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule